// File: doc/BRIEF.md
# Trap Vector and Level Selector

This block takes a trap that is about to be taken and decides where it goes. It works out the privilege level the core is running at, looks up the level the trap asks for at that level, and applies the trap-level limits. From these it picks one of four outcomes: a reset-style RED entry, a hyperprivileged entry, a privileged entry, or the error state. It then forms the handler address (PC), the address after it (NPC) and the trap type the handler is indexed by.

A trap is presented with `req_i` for one cycle, and the result appears on the outputs one clock later with `vld_o` high. A power-on request `por_i` overrides everything else and sends the core to the RED entry point for trap type 1. Saving the trap state and fetching from the handler are left to the surrounding pipeline.

Top module: `trapsel_top`

## Requirements
- R1: After reset `vld_o` is 0 and `mode_o`, `vtt_o`, `pc_o` and `npc_o` are all 0.
- R2: The current level is hyperprivileged when `hpstate_hpriv_i` is 1, otherwise privileged when `pstate_priv_i` is 1, otherwise user. The requested next level is `lvl_tbl_i[0]` for user, `[1]` for privileged and `[2]` for hyperprivileged, where 1 means hyperprivileged and 0 means privileged.
- R3: `por_i` takes priority over every other input. It gives mode RED (`mode_o`=2) and `vtt_o`=1, with `pc_o` = RED_BASE | 0x20.
- R4: Otherwise, when `hpstate_red_i` is 1 or TL equals MAX_TL-1, the result is mode RED with `vtt_o`=5 and `pc_o` = RED_BASE | 0xA0. In general the RED address is RED_BASE | ((vtt<<5) & 0xFF).
- R5: Otherwise, when TL is MAX_TL or above, the result is mode ERROR (`mode_o`=3), `vtt_o` equals the trap type, and `pc_o` and `npc_o` are 0.
- R6: Otherwise, when TL is above MAX_PTL and the requested level is privileged, the result is mode HYPER (`mode_o`=1) with `vtt_o`=2.
- R7: Otherwise, when the requested level is hyperprivileged, or it is privileged and the trap type is 384 or more, the result is mode HYPER with `vtt_o` equal to the trap type. A HYPER `pc_o` is `htba_i` with bits 13:0 replaced by vtt<<5.
- R8: In every other case the result is mode PRIV (`mode_o`=0) with `vtt_o` equal to the trap type. `pc_o` is `tba_i` with bits 14:0 replaced: bit 14 is 1 when the incoming TL is 1 or more, and bits 13:0 are tt<<5.
- R9: For every mode except ERROR, `npc_o` equals `pc_o` + 4.
- R10: The outputs update on the clock after a cycle with `req_i` or `por_i` high, and `vld_o` is high in exactly those cycles. In any other cycle `vld_o` is 0 and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | A trap is presented this cycle |
| por_i | input | 1 | Power-on reset request |
| tt_i | input | 9 | Trap type |
| tl_i | input | TL_W (3) | Current trap level |
| pstate_priv_i | input | 1 | Privileged-mode bit |
| hpstate_hpriv_i | input | 1 | Hyperprivileged-mode bit |
| hpstate_red_i | input | 1 | Already in RED state |
| lvl_tbl_i | input | 3 | Next level for each current level (1 = hyper) |
| tba_i | input | ADDR_W (64) | Privileged trap base |
| htba_i | input | ADDR_W (64) | Hyperprivileged trap base |
| vld_o | output | 1 | Result valid |
| mode_o | output | 2 | 0 PRIV, 1 HYPER, 2 RED, 3 ERROR |
| vtt_o | output | 9 | Trap type used for vectoring |
| pc_o | output | ADDR_W (64) | Handler PC |
| npc_o | output | ADDR_W (64) | Handler NPC |

## Verification
The bench builds the block with its defaults: MAX_TL 6, MAX_PTL 2, 64-bit addresses and a 4-byte instruction step. A 3-bit TL then reaches every threshold region: below MAX_PTL, the range where a guest is escalated, the RED point at 5, the error point at 6, and the beyond-limit value 7. Trap types are drawn on both sides of 384, and bases are full 64-bit random values, so the masked low bits of both vector forms and the high-order bits carried through from the bases are both exercised.

// File: rtl/trapsel_pkg.sv
package trapsel_pkg;
   localparam int TT_W        = 9;
   localparam int OFF_W       = TT_W + 5;
   localparam int HYPER_FLOOR = 384;
   localparam logic [TT_W-1:0] TT_POR      = 9'd1;
   localparam logic [TT_W-1:0] TT_GUEST_WD = 9'd2;
   localparam logic [TT_W-1:0] TT_RED      = 9'd5;

   typedef enum logic [1:0] {
      TS_PRIV  = 2'd0,
      TS_HYPER = 2'd1,
      TS_RED   = 2'd2,
      TS_ERROR = 2'd3
   } ts_mode_e;

   typedef enum logic [1:0] {
      LV_USER  = 2'd0,
      LV_PRIV  = 2'd1,
      LV_HYPER = 2'd2
   } ts_level_e;

   typedef struct packed {
      ts_mode_e        mode;
      logic [TT_W-1:0] vtt;
   } ts_route_t;
endpackage

// File: rtl/trapsel_level.sv
module trapsel_level
   import trapsel_pkg::*;
(
   input  logic       priv_i,
   input  logic       hpriv_i,
   input  logic [2:0] lvl_tbl_i,
   output ts_level_e  cur_o,
   output logic       next_hyper_o
);
   always_comb begin
      if (hpriv_i)     cur_o = LV_HYPER;
      else if (priv_i) cur_o = LV_PRIV;
      else             cur_o = LV_USER;
   end

   always_comb begin
      unique case (cur_o)
         LV_HYPER: next_hyper_o = lvl_tbl_i[2];
         LV_PRIV:  next_hyper_o = lvl_tbl_i[1];
         default:  next_hyper_o = lvl_tbl_i[0];
      endcase
   end
endmodule

// File: rtl/trapsel_route.sv
module trapsel_route
   import trapsel_pkg::*;
#(
   parameter int MAX_TL  = 6,
   parameter int MAX_PTL = 2,
   parameter int TL_W    = 3
) (
   input  logic            por_i,
   input  logic            red_i,
   input  logic [TL_W-1:0] tl_i,
   input  logic            next_hyper_i,
   input  logic [TT_W-1:0] tt_i,
   output ts_route_t       route_o
);
   localparam logic [TL_W-1:0] RED_TL  = TL_W'(MAX_TL - 1);
   localparam logic [TL_W-1:0] ERR_TL  = TL_W'(MAX_TL);
   localparam logic [TL_W-1:0] GUEST_TL = TL_W'(MAX_PTL);

   logic high_tt;
   assign high_tt = (tt_i >= TT_W'(HYPER_FLOOR));

   always_comb begin
      route_o.vtt = tt_i;
      if (por_i) begin
         route_o.mode = TS_RED;
         route_o.vtt  = TT_POR;
      end else if (red_i || tl_i == RED_TL) begin
         route_o.mode = TS_RED;
         route_o.vtt  = TT_RED;
      end else if (tl_i >= ERR_TL) begin
         route_o.mode = TS_ERROR;
      end else if (tl_i > GUEST_TL && !next_hyper_i) begin
         route_o.mode = TS_HYPER;
         route_o.vtt  = TT_GUEST_WD;
      end else if (next_hyper_i || high_tt) begin
         route_o.mode = TS_HYPER;
      end else begin
         route_o.mode = TS_PRIV;
      end
   end
endmodule

// File: rtl/trapsel_vecgen.sv
module trapsel_vecgen
   import trapsel_pkg::*;
#(
   parameter int                  ADDR_W     = 64,
   parameter logic [ADDR_W-1:0]   RED_BASE   = ADDR_W'(64'hFF_F000_0000),
   parameter int                  INST_BYTES = 4,
   parameter bit                  ERR_TO_RED = 1'b0
) (
   input  ts_route_t         route_i,
   input  logic              tl_nz_i,
   input  logic [ADDR_W-1:0] tba_i,
   input  logic [ADDR_W-1:0] htba_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o
);
   logic [OFF_W-1:0]  off;
   logic [ADDR_W-1:0] red_pc, hyp_pc, prv_pc, err_pc;

   assign off    = {route_i.vtt, 5'b0_0000};
   assign red_pc = RED_BASE | ADDR_W'(off[7:0]);
   assign hyp_pc = {htba_i[ADDR_W-1:OFF_W], off};
   assign prv_pc = {tba_i[ADDR_W-1:OFF_W+1], tl_nz_i, off};

   generate
      if (ERR_TO_RED) begin : g_err_red
         assign err_pc = red_pc;
      end else begin : g_err_zero
         assign err_pc = '0;
      end
   endgenerate

   always_comb begin
      unique case (route_i.mode)
         TS_RED:   pc_o = red_pc;
         TS_HYPER: pc_o = hyp_pc;
         TS_PRIV:  pc_o = prv_pc;
         default:  pc_o = err_pc;
      endcase
      if (route_i.mode == TS_ERROR && !ERR_TO_RED) npc_o = '0;
      else npc_o = pc_o + ADDR_W'(INST_BYTES);
   end
endmodule

// File: rtl/trapsel_top.sv
module trapsel_top
   import trapsel_pkg::*;
#(
   parameter int                ADDR_W     = 64,
   parameter int                MAX_TL     = 6,
   parameter int                MAX_PTL    = 2,
   parameter int                INST_BYTES = 4,
   parameter logic [ADDR_W-1:0] RED_BASE   = ADDR_W'(64'hFF_F000_0000),
   parameter bit                ERR_TO_RED = 1'b0,
   localparam int               TL_W       = $clog2(MAX_TL + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              por_i,
   input  logic [8:0]        tt_i,
   input  logic [TL_W-1:0]   tl_i,
   input  logic              pstate_priv_i,
   input  logic              hpstate_hpriv_i,
   input  logic              hpstate_red_i,
   input  logic [2:0]        lvl_tbl_i,
   input  logic [ADDR_W-1:0] tba_i,
   input  logic [ADDR_W-1:0] htba_i,
   output logic              vld_o,
   output logic [1:0]        mode_o,
   output logic [8:0]        vtt_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o
);
   ts_level_e         cur_lvl;
   logic              next_hyper;
   ts_route_t         route;
   logic [ADDR_W-1:0] pc_c, npc_c;

   trapsel_level u_level (
      .priv_i       (pstate_priv_i),
      .hpriv_i      (hpstate_hpriv_i),
      .lvl_tbl_i    (lvl_tbl_i),
      .cur_o        (cur_lvl),
      .next_hyper_o (next_hyper)
   );

   trapsel_route #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W)) u_route (
      .por_i        (por_i),
      .red_i        (hpstate_red_i),
      .tl_i         (tl_i),
      .next_hyper_i (next_hyper),
      .tt_i         (tt_i),
      .route_o      (route)
   );

   trapsel_vecgen #(
      .ADDR_W(ADDR_W), .RED_BASE(RED_BASE),
      .INST_BYTES(INST_BYTES), .ERR_TO_RED(ERR_TO_RED)
   ) u_vec (
      .route_i (route),
      .tl_nz_i (tl_i != '0),
      .tba_i   (tba_i),
      .htba_i  (htba_i),
      .pc_o    (pc_c),
      .npc_o   (npc_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         mode_o <= 2'd0;
         vtt_o  <= '0;
         pc_o   <= '0;
         npc_o  <= '0;
      end else begin
         vld_o <= req_i | por_i;
         if (req_i | por_i) begin
            mode_o <= route.mode;
            vtt_o  <= route.vtt;
            pc_o   <= pc_c;
            npc_o  <= npc_c;
         end
      end
   end
endmodule

// File: rtl/trapsel_chk.sv
module trapsel_chk
#(
   parameter int ADDR_W     = 64,
   parameter int MAX_TL     = 6,
   parameter int MAX_PTL    = 2,
   parameter int INST_BYTES = 4,
   parameter int TL_W       = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              por_i,
   input logic [8:0]        tt_i,
   input logic [TL_W-1:0]   tl_i,
   input logic              hpstate_red_i,
   input logic [ADDR_W-1:0] htba_i,
   input logic              vld_o,
   input logic [1:0]        mode_o,
   input logic [8:0]        vtt_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] npc_o
);
   initial begin
      cfg_tl_order_chk: assert (MAX_PTL < MAX_TL - 1);
      cfg_addr_chk:     assert (ADDR_W >= 40);
   end

   // R10
   vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i || por_i) |=> vld_o);
   // R10
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_i && !por_i) |=> (!vld_o && $stable(pc_o) && $stable(mode_o)));
   // R3
   por_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_i |=> (mode_o == 2'd2 && vtt_o == 9'd1));
   // R4
   red_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !por_i && hpstate_red_i) |=> (mode_o == 2'd2 && vtt_o == 9'd5));
   // R5
   tl_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !por_i && !hpstate_red_i && tl_i >= TL_W'(MAX_TL))
      |=> (mode_o == 2'd3 && vtt_o == $past(tt_i)));
   // R7
   hyper_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !por_i) |=> (mode_o != 2'd1 ||
         pc_o[ADDR_W-1:14] == $past(htba_i[ADDR_W-1:14])));
   // R9
   npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && mode_o != 2'd3) |-> (npc_o == pc_o + ADDR_W'(INST_BYTES)));
endmodule

bind trapsel_top trapsel_chk #(
   .ADDR_W(ADDR_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL),
   .INST_BYTES(INST_BYTES), .TL_W(TL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .por_i(por_i), .tt_i(tt_i),
   .tl_i(tl_i), .hpstate_red_i(hpstate_red_i), .htba_i(htba_i),
   .vld_o(vld_o), .mode_o(mode_o), .vtt_o(vtt_o), .pc_o(pc_o), .npc_o(npc_o)
);

// File: tb/tb_trapsel_top.sv
module tb_trapsel_top;
   localparam int MTL = 6;
   localparam int MPTL = 2;
   localparam logic [63:0] RBASE = 64'hFF_F000_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_i, por_i, priv, hpriv, red;
   logic [8:0]  tt;
   logic [2:0]  tl;
   logic [2:0]  tbl;
   logic [63:0] tba, htba;
   logic        vld_o;
   logic [1:0]  mode_o;
   logic [8:0]  vtt_o;
   logic [63:0] pc_o, npc_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   logic        e_vld;
   logic [1:0]  e_mode;
   logic [8:0]  e_vtt;
   logic [63:0] e_pc, e_npc;
   string       e_tag;

   always #5 clk = ~clk;

   trapsel_top dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .por_i(por_i), .tt_i(tt),
      .tl_i(tl), .pstate_priv_i(priv), .hpstate_hpriv_i(hpriv),
      .hpstate_red_i(red), .lvl_tbl_i(tbl), .tba_i(tba), .htba_i(htba),
      .vld_o(vld_o), .mode_o(mode_o), .vtt_o(vtt_o), .pc_o(pc_o), .npc_o(npc_o)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic compare();
      n_chk++;
      if (vld_o !== e_vld || mode_o !== e_mode || vtt_o !== e_vtt || pc_o !== e_pc) begin
         n_bad++;
         $display("FAIL %s: actual v=%0b m=%0d tt=%0h pc=%h expected v=%0b m=%0d tt=%0h pc=%h",
                  e_tag, vld_o, mode_o, vtt_o, pc_o, e_vld, e_mode, e_vtt, e_pc);
      end
      n_chk++;
      if (npc_o !== e_npc) begin
         n_bad++;
         $display("FAIL R9 npc: actual %h expected %h", npc_o, e_npc);
      end
   endtask

   // behavioural reference of the requirements
   task automatic model();
      logic nh;
      int   lvl;
      logic [63:0] off;
      if (!req_i && !por_i) begin
         e_vld = 0; e_tag = "R10 idle";
         return;
      end
      e_vld = 1;
      lvl = hpriv ? 2 : (priv ? 1 : 0);           // R2
      nh  = tbl[lvl];
      e_vtt = tt;
      if (por_i) begin
         e_mode = 2; e_vtt = 1; e_tag = "R3 por";
      end else if (red || int'(tl) == MTL - 1) begin
         e_mode = 2; e_vtt = 5; e_tag = "R4 red";
      end else if (int'(tl) >= MTL) begin
         e_mode = 3; e_tag = "R5 error";
      end else if (int'(tl) > MPTL && !nh) begin
         e_mode = 1; e_vtt = 2; e_tag = "R6 guest escalate";
      end else if (nh || int'(tt) >= 384) begin
         e_mode = 1; e_tag = "R7 hyper";
      end else begin
         e_mode = 0; e_tag = "R8 R2 priv";
      end
      off = 64'(e_vtt) * 32;
      case (e_mode)
         2'd2: e_pc = RBASE | (off & 64'hFF);
         2'd1: e_pc = (htba & ~64'h3FFF) | off;
         2'd0: e_pc = (tba & ~64'h7FFF) | ((tl >= 1) ? 64'h4000 : 64'h0) | off;
         default: e_pc = 64'h0;
      endcase
      e_npc = (e_mode == 2'd3) ? 64'h0 : e_pc + 64'd4;
   endtask

   task automatic apply(input logic r, input logic p, input logic [8:0] t,
                        input logic [2:0] l, input logic pv, input logic hp,
                        input logic rd, input logic [2:0] tb);
      @(negedge clk);
      compare();
      req_i = r; por_i = p; tt = t; tl = l; priv = pv; hpriv = hp; red = rd; tbl = tb;
      tba  = {$urandom, $urandom};
      htba = {$urandom, $urandom};
      model();
   endtask

   initial begin
      rst_n = 0; req_i = 0; por_i = 0; tt = 0; tl = 0; priv = 0; hpriv = 0;
      red = 0; tbl = 0; tba = 0; htba = 0;
      e_vld = 0; e_mode = 0; e_vtt = 0; e_pc = 0; e_npc = 0; e_tag = "R1 reset";
      repeat (3) @(negedge clk);
      compare();                                   // R1
      rst_n = 1;
      // directed corners
      apply(0, 1, 9'h0A0, 3'd0, 0, 0, 0, 3'b000);  // R3 por
      apply(1, 1, 9'h010, 3'd7, 1, 1, 1, 3'b111);  // R3 priority
      apply(1, 0, 9'h024, 3'd1, 1, 0, 1, 3'b000);  // R4 red bit
      apply(1, 0, 9'h024, 3'd5, 0, 0, 0, 3'b000);  // R4 TL=MAX-1
      apply(1, 0, 9'h034, 3'd6, 1, 0, 0, 3'b000);  // R5 TL=MAX
      apply(1, 0, 9'h034, 3'd7, 1, 0, 0, 3'b000);  // R5 beyond
      apply(1, 0, 9'h020, 3'd3, 1, 0, 0, 3'b000);  // R6
      apply(1, 0, 9'h020, 3'd2, 1, 0, 0, 3'b000);  // R8 at MAX_PTL
      apply(1, 0, 9'h180, 3'd1, 0, 0, 0, 3'b000);  // R7 tt=384
      apply(1, 0, 9'h17F, 3'd1, 0, 0, 0, 3'b000);  // R8 tt=383
      apply(1, 0, 9'h010, 3'd0, 0, 0, 0, 3'b001);  // R2 user entry hyper
      apply(1, 0, 9'h010, 3'd0, 1, 0, 0, 3'b001);  // R2 priv entry
      apply(1, 0, 9'h010, 3'd0, 1, 1, 0, 3'b011);  // R2 hyper entry
      apply(0, 0, 9'h1FF, 3'd7, 1, 1, 1, 3'b111);  // R10 idle hold
      apply(1, 0, 9'h1FF, 3'd4, 0, 1, 0, 3'b100);  // R7 max tt
      apply(1, 0, 9'h041, 3'd0, 1, 0, 0, 3'b000);  // R8 TL=0 no bit14
      for (int i = 0; i < 600; i++) begin
         apply(($urandom % 4) != 0, ($urandom % 20) == 0, 9'($urandom),
               3'($urandom), 1'($urandom), 1'($urandom % 3 == 0),
               1'($urandom % 8 == 0), 3'($urandom));
      end
      apply(0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      compare();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule